// File: doc/BRIEF.md
# Video Processor Command Word Decoder

This block sits behind the control port of a video processor. It takes 16-bit words written to that port and turns them into one of two things. A single word can load one entry of a 32-entry, 8-bit configuration register file. Two words in a row can instead build a 16-bit access address and a 6-bit access code. These are later used by data-port transfers. A pending flag records that the first half of a two-word command has arrived.

When the second half lands, the decoder checks the new access code against the configuration registers. From that it decides whether to launch a DMA operation and which kind. Data-port accesses and status reads are signalled to the block by strobes. Every data-port access advances the address by a programmable step.

The upper two address bits come from a latch that remembers the last second word. A first word combines that latch with its own fourteen low bits. It does not use the live address, which may have been carried upward by auto-increment.

Top module: `cmd_word_decoder`

## Requirements
- R1: After reset, `pend`, `acc_addr`, `acc_code`, `dma_kind`, `reg_sel` and `reg_val` are zero, and `reg_we` and `dma_go` are low. The address-high latch and all 32 configuration entries are also zero.
- R2: A control word taken while `pend` is low with bits 15:14 equal to 2'b10 is a register write. Exactly one cycle later `reg_we` pulses high for one cycle, with `reg_sel` = bits 12:8 and `reg_val` = bits 7:0. That entry is stored, and `pend` stays low.
- R3: Any control word taken while `pend` is low, register write or not, has three effects. It loads `acc_addr[13:0]` from bits 13:0. It loads `acc_code[1:0]` from bits 15:14. It loads `acc_addr[15:14]` from the address-high latch. A word that is not a register write also sets `pend`.
- R4: A control word taken while `pend` is high is a second word, even if its bits 15:14 are 2'b10. It clears `pend`. It loads `acc_addr[15:14]` and the address-high latch from bits 1:0 and `acc_code[5:2]` from bits 7:4. It leaves the other bits alone and raises no `reg_we`.
- R5: The address-high latch changes only on a second word. An auto-increment that carries into `acc_addr[15:14]` does not affect the high bits applied by the next first word.
- R6: A second word whose bit 7 (new code bit 5) is set starts a DMA, but only while bit 4 of register 1 is set. The start is a one-cycle `dma_go` pulse one cycle later. `dma_kind` is set from bits 7:6 of register 23: 2'b00 or 2'b01 give 2'b00 (external bus transfer), 2'b10 gives 2'b10 (fill), and 2'b11 gives 2'b11 (copy). Otherwise `dma_go` stays low.
- R7: A data-port access (`data_acc`) or a status read (`stat_rd`) in a cycle without `ctl_wr` clears `pend`.
- R8: Each `data_acc` without `ctl_wr` adds register 15, zero-extended, to `acc_addr` modulo 2^16. `stat_rd` leaves `acc_addr` unchanged.
- R9: When `ctl_wr` is high, `data_acc` and `stat_rd` are ignored in that cycle. No increment happens and `pend` follows only the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control-port word strobe |
| ctl_data | input | 16 | Control-port word |
| data_acc | input | 1 | Data-port read or write strobe |
| stat_rd | input | 1 | Status read strobe |
| pend | output | 1 | First half of a two-word command held |
| acc_addr | output | 16 | Access address |
| acc_code | output | 6 | Access code |
| reg_we | output | 1 | Register write pulse |
| reg_sel | output | 5 | Register index of last write |
| reg_val | output | 8 | Value of last register write |
| dma_go | output | 1 | DMA start pulse |
| dma_kind | output | 2 | DMA type for the last start |

## Verification
The bench first drives the step so that the address carries into bit 14, then issues a new first word. A design that took the high bits from the live address would return 0x4010 instead of 0x0010.

It also sends a second word shaped like a register write. A decoder that ignored `pend` would pulse `reg_we` and corrupt a register.

Further checks cover three more cases:
- DMA with the enable bit cleared and with code bit 5 clear. A faulty design would pulse `dma_go` here.
- Each mode-field value, including the 2'b01 alias.
- Address wrap past 0xFFFF, and control words that collide with data or status strobes. A faulty design would increment or clear `pend` wrongly in the collision case.

// File: rtl/cmd_word_decoder.sv
module cmd_word_decoder #(
  parameter int EN_REG   = 1,
  parameter int INC_REG  = 15,
  parameter int MODE_REG = 23,
  parameter int EN_BIT   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_wr,
  input  logic [15:0] ctl_data,
  input  logic        data_acc,
  input  logic        stat_rd,
  output logic        pend,
  output logic [15:0] acc_addr,
  output logic [5:0]  acc_code,
  output logic        reg_we,
  output logic [4:0]  reg_sel,
  output logic [7:0]  reg_val,
  output logic        dma_go,
  output logic [1:0]  dma_kind
);
  logic [7:0] cfg [32];
  logic [1:0] hi_latch;

  wire       is_regw  = ctl_data[15:14] == 2'b10;
  wire [7:0] mode_r   = cfg[MODE_REG];
  wire       dma_en   = cfg[EN_REG][EN_BIT];
  wire [1:0] kind_new = mode_r[7] ? mode_r[7:6] : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) cfg[i] <= '0;
      hi_latch <= '0;
      pend     <= 1'b0;
      acc_addr <= '0;
      acc_code <= '0;
      reg_we   <= 1'b0;
      reg_sel  <= '0;
      reg_val  <= '0;
      dma_go   <= 1'b0;
      dma_kind <= '0;
    end else begin
      reg_we <= 1'b0;
      dma_go <= 1'b0;
      if (ctl_wr) begin
        if (!pend) begin
          acc_addr      <= {hi_latch, ctl_data[13:0]};
          acc_code[1:0] <= ctl_data[15:14];
          if (is_regw) begin
            cfg[ctl_data[12:8]] <= ctl_data[7:0];
            reg_we  <= 1'b1;
            reg_sel <= ctl_data[12:8];
            reg_val <= ctl_data[7:0];
          end else begin
            pend <= 1'b1;
          end
        end else begin
          pend           <= 1'b0;
          acc_addr[15:14] <= ctl_data[1:0];
          hi_latch       <= ctl_data[1:0];
          acc_code[5:2]  <= ctl_data[7:4];
          if (ctl_data[7] && dma_en) begin
            dma_go   <= 1'b1;
            dma_kind <= kind_new;
          end
        end
      end else begin
        if (data_acc || stat_rd) pend <= 1'b0;
        if (data_acc) acc_addr <= acc_addr + {8'b0, cfg[INC_REG]};
      end
    end
  end
endmodule

module cmd_word_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_wr,
  input logic [15:0] ctl_data,
  input logic        data_acc,
  input logic        stat_rd,
  input logic        pend,
  input logic [15:0] acc_addr,
  input logic [5:0]  acc_code,
  input logic        reg_we,
  input logic        dma_go
);
  assert_regw_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(ctl_wr && !pend && ctl_data[15:14] == 2'b10));

  assert_pend_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(ctl_wr));

  assert_first_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !pend) |=> (acc_addr[13:0] == $past(ctl_data[13:0])));

  assert_second_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && pend) |=> (!pend && acc_addr[15:14] == $past(ctl_data[1:0])
                          && acc_code[5:2] == $past(ctl_data[7:4])));

  assert_dma_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_go |-> $past(ctl_wr && pend && ctl_data[7]));

  assert_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_wr && (data_acc || stat_rd)) |=> !pend);

  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_wr && !data_acc) |=> $stable(acc_addr));
endmodule

bind cmd_word_decoder cmd_word_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
  .data_acc(data_acc), .stat_rd(stat_rd), .pend(pend), .acc_addr(acc_addr),
  .acc_code(acc_code), .reg_we(reg_we), .dma_go(dma_go)
);

// File: tb/cmd_word_decoder_test.sv
module cmd_word_decoder_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [15:0] ctl_data = '0;
  logic        data_acc = 1'b0;
  logic        stat_rd = 1'b0;
  logic        pend;
  logic [15:0] acc_addr;
  logic [5:0]  acc_code;
  logic        reg_we;
  logic [4:0]  reg_sel;
  logic [7:0]  reg_val;
  logic        dma_go;
  logic [1:0]  dma_kind;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_word_decoder uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cw(logic [15:0] d, logic da = 1'b0, logic sr = 1'b0);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_data = d; data_acc = da; stat_rd = sr;
    @(negedge clk);
    ctl_wr = 1'b0; data_acc = 1'b0; stat_rd = 1'b0;
  endtask

  task automatic da_pulse();
    @(negedge clk); data_acc = 1'b1;
    @(negedge clk); data_acc = 1'b0;
  endtask

  task automatic sr_pulse();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 pend", pend, 0);
    chk("R1 addr", acc_addr, 0);
    chk("R1 code", acc_code, 0);
    chk("R1 strobes", {reg_we, dma_go, dma_kind}, 0);
  endtask

  task automatic t_regwrite();
    cw(16'h8F02);
    chk("R2 reg_we", reg_we, 1);
    chk("R2 sel/val", {reg_sel, reg_val}, {5'd15, 8'h02});
    chk("R2 pend", pend, 0);
    chk("R3 regw addr", acc_addr, 16'h0F02);
    chk("R3 regw code", acc_code, 6'h02);
    @(negedge clk);
    chk("R2 pulse width", reg_we, 0);
    cw(16'h8110);
    cw(16'h9780);
  endtask

  task automatic t_two_word();
    cw(16'h7FFE);
    chk("R3 pend set", pend, 1);
    chk("R3 first addr", acc_addr, 16'h3FFE);
    chk("R3 first code", acc_code, 6'h01);
    chk("R3 no reg_we", reg_we, 0);
    cw(16'h0000);
    chk("R4 pend clear", pend, 0);
    chk("R4 addr", acc_addr, 16'h3FFE);
    chk("R6 no dma when code5 clear", dma_go, 0);
  endtask

  task automatic t_latch();
    da_pulse();
    chk("R8 increment carry", acc_addr, 16'h4000);
    sr_pulse();
    chk("R8 status no inc", acc_addr, 16'h4000);
    cw(16'h4010);
    chk("R5 latch not live", acc_addr, 16'h0010);
    chk("R5 code", acc_code, 6'h01);
    da_pulse();
    chk("R7 data cancels", pend, 0);
    chk("R8 inc after cancel", acc_addr, 16'h0012);
  endtask

  task automatic t_dma();
    cw(16'h4000);
    cw(16'h0083);
    chk("R6 dma fill go", dma_go, 1);
    chk("R6 fill kind", dma_kind, 2'b10);
    chk("R4 high bits", acc_addr, 16'hC000);
    chk("R4 code", acc_code, 6'h21);
    @(negedge clk);
    chk("R6 pulse width", dma_go, 0);
    cw(16'h4005);
    chk("R5 latch reloaded", acc_addr, 16'hC005);
    sr_pulse();
    chk("R7 status cancels", pend, 0);
    cw(16'h8100);
    chk("R3 regw uses latch", acc_addr, 16'hC100);
    chk("R3 regw code low", acc_code, 6'h22);
    cw(16'h4000); cw(16'h0080);
    chk("R6 disabled", dma_go, 0);
    cw(16'h8110);
    cw(16'h97C0);
    cw(16'h4000); cw(16'h0080);
    chk("R6 copy", {dma_go, dma_kind}, {1'b1, 2'b11});
    cw(16'h9740);
    cw(16'h4000); cw(16'h0080);
    chk("R6 bus alias", {dma_go, dma_kind}, {1'b1, 2'b00});
    cw(16'h9700);
    cw(16'h4000); cw(16'h0040);
    chk("R6 code5 clear", dma_go, 0);
  endtask

  task automatic t_second_regpattern();
    cw(16'h4001);
    cw(16'h8F00);
    chk("R4 no reg_we", reg_we, 0);
    chk("R4 pend clear", pend, 0);
    cw(16'h8F20);
    chk("R2 step written", {reg_we, reg_sel, reg_val}, {1'b1, 5'd15, 8'h20});
  endtask

  task automatic t_collide_wrap();
    cw(16'h7FF0);
    cw(16'h0003);
    chk("R4 wrap setup", acc_addr, 16'hFFF0);
    da_pulse();
    chk("R8 wrap", acc_addr, 16'h0010);
    cw(16'h4100, 1'b1, 1'b1);
    chk("R9 pend kept", pend, 1);
    chk("R9 no inc", acc_addr, 16'hC100);
    cw(16'h0000, 1'b1, 1'b0);
    chk("R9 second wins", acc_addr, 16'h0100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regwrite();
    t_two_word();
    t_latch();
    t_dma();
    t_second_regpattern();
    t_collide_wrap();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule